// File: doc/BRIEF.md
# Incremental Encoder Emulator

This block turns a 16-bit absolute angle word into the A, B and zero-index signals of an incremental optical encoder. Control logic written for optical encoders can then run from an absolute position source without being changed. Two bits of the angle word drive the quadrature pair. Which two bits are used depends on the encoder resolution in force.

Emulation is active while the active-low mode input is held low. The resolution code is sampled from a two-bit data input at the moment the mode input falls. It then stays fixed until the mode input falls again. A separate active-low enable gates the index output. An error flag reports a captured resolution finer than the resolution of the parallel angle output, which is set by the `OUT_RES` parameter.

Top module: `enc_emulator`

## Requirements
- R1: While the registered mode input is high (emulation off), enc_a, enc_b and enc_z are low on every cycle.
- R2: In emulation, enc_a equals angle bit LSB+1 one clock after the angle is sampled, where LSB is the encoder LSB chosen by the resolution code.
- R3: In emulation, enc_b equals angle bit LSB XOR angle bit LSB+1 one clock after the angle is sampled.
- R4: Resolution code 00, 01, 10 and 11 selects 10, 12, 14 and 16 bits. The encoder LSB is then angle bit 6, 4, 2 and 0, and angle bits below the LSB have no effect on the outputs.
- R5: The resolution code is captured from res_sel on the clock edge at which mode_n is first seen low after being high. Changes on res_sel at any other time, including a rising edge of mode_n, have no effect.
- R6: After a synchronous reset, enc_a, enc_b, enc_z and res_err are low and the resolution code is 00.
- R7: In emulation with idx_en_n low, enc_z is high exactly when angle bits 15 down to LSB are all zero, one clock after sampling.
- R8: With idx_en_n high, enc_z stays low.
- R9: res_err is set at capture when the selected resolution exceeds OUT_RES, is cleared at a capture that does not, and changes at no other time.
- R10: As the angle increases by one encoder LSB per step, the (A,B) pair steps through (0,0), (0,1), (1,1), (1,0), so B leads A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_n | input | 1 | Emulation select, low = emulate; falling edge captures resolution |
| res_sel | input | 2 | Resolution code captured on mode_n fall |
| idx_en_n | input | 1 | Active-low zero-index enable |
| angle | input | 16 | Absolute angle word |
| enc_a | output | 1 | Quadrature A |
| enc_b | output | 1 | Quadrature B |
| enc_z | output | 1 | Zero index |
| res_err | output | 1 | Encoder resolution exceeds parallel output resolution |

## Verification
The bench sets OUT_RES to 14 and leaves the other parameters at their defaults. With that setting, codes 00 to 10 are accepted and code 11 (16 bits) raises the error flag, so both setting and clearing res_err can be exercised. Every resolution code is visited, which moves the encoder LSB across all four of its positions. At each position the index window and the insensitivity to the bits below the LSB are checked.

// File: rtl/enc_emu_pkg.sv
package enc_emu_pkg;

  // Number of encoder bits selected by a resolution code
  function automatic int code_to_bits(input int code, input int base_res,
                                      input int res_step);
    return base_res + res_step * code;
  endfunction

  // Angle bit acting as the encoder LSB for a resolution code
  function automatic int code_to_lsb(input int code, input int angle_w,
                                     input int base_res, input int res_step);
    return angle_w - code_to_bits(code, base_res, res_step);
  endfunction

endpackage

// File: rtl/enc_res_latch.sv
module enc_res_latch #(
  parameter int CODE_W   = 2,
  parameter int BASE_RES = 10,
  parameter int RES_STEP = 2,
  parameter int OUT_RES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_n,
  input  logic [CODE_W-1:0] res_pins,
  output logic              emul_n,
  output logic [CODE_W-1:0] code_q,
  output logic              err_q
);
  import enc_emu_pkg::*;

  logic mode_q;
  logic fall;
  logic too_fine;

  assign fall     = mode_q & ~mode_n;
  assign too_fine = code_to_bits(int'(res_pins), BASE_RES, RES_STEP) > OUT_RES;
  assign emul_n   = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b1;
      code_q <= '0;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      if (fall) begin
        code_q <= res_pins;
        err_q  <= too_fine;
      end
    end
  end

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(code_q));

  // R5
  code_capture_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> (code_q == $past(res_pins)));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(err_q));

endmodule

// File: rtl/enc_quad_gen.sv
module enc_quad_gen #(
  parameter int ANGLE_W  = 16,
  parameter int CODE_W   = 2,
  parameter int BASE_RES = 10,
  parameter int RES_STEP = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               emul_n,
  input  logic               idx_en_n,
  input  logic [ANGLE_W-1:0] angle,
  input  logic [CODE_W-1:0]  code,
  output logic               a_o,
  output logic               b_o,
  output logic               z_o
);
  import enc_emu_pkg::*;

  localparam int NCODES = 2 ** CODE_W;

  logic [NCODES-1:0] a_opt, b_opt, z_opt;

  for (genvar k = 0; k < NCODES; k++) begin : g_res
    localparam int LSB = code_to_lsb(k, ANGLE_W, BASE_RES, RES_STEP);
    assign a_opt[k] = angle[LSB+1];
    assign b_opt[k] = angle[LSB] ^ angle[LSB+1];
    assign z_opt[k] = ~|angle[ANGLE_W-1:LSB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_o <= 1'b0;
      b_o <= 1'b0;
      z_o <= 1'b0;
    end else begin
      a_o <= ~emul_n & a_opt[code];
      b_o <= ~emul_n & b_opt[code];
      z_o <= ~emul_n & ~idx_en_n & z_opt[code];
    end
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    emul_n |=> (!a_o && !b_o && !z_o));

  // R8
  index_gate_chk: assert property (@(posedge clk) disable iff (rst)
    idx_en_n |=> !z_o);

  // R7
  north_state_chk: assert property (@(posedge clk) disable iff (rst)
    z_o |-> (!a_o && !b_o));

endmodule

// File: rtl/enc_emulator.sv
module enc_emulator #(
  parameter int ANGLE_W  = 16,
  parameter int CODE_W   = 2,
  parameter int BASE_RES = 10,
  parameter int RES_STEP = 2,
  parameter int OUT_RES  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_n,
  input  logic [CODE_W-1:0]  res_sel,
  input  logic               idx_en_n,
  input  logic [ANGLE_W-1:0] angle,
  output logic               enc_a,
  output logic               enc_b,
  output logic               enc_z,
  output logic               res_err
);

  logic              emul_n;
  logic [CODE_W-1:0] code_q;

  enc_res_latch #(
    .CODE_W(CODE_W), .BASE_RES(BASE_RES), .RES_STEP(RES_STEP), .OUT_RES(OUT_RES)
  ) u_latch (
    .clk(clk), .rst(rst), .mode_n(mode_n), .res_pins(res_sel),
    .emul_n(emul_n), .code_q(code_q), .err_q(res_err)
  );

  enc_quad_gen #(
    .ANGLE_W(ANGLE_W), .CODE_W(CODE_W), .BASE_RES(BASE_RES), .RES_STEP(RES_STEP)
  ) u_quad (
    .clk(clk), .rst(rst), .emul_n(emul_n), .idx_en_n(idx_en_n),
    .angle(angle), .code(code_q), .a_o(enc_a), .b_o(enc_b), .z_o(enc_z)
  );

  // R6
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!enc_a && !enc_b && !enc_z && !res_err));

endmodule

// File: tb/test_enc_emulator.sv
module test_enc_emulator;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        mode_n;
  logic [1:0]  res_sel;
  logic        idx_en_n;
  logic [15:0] angle;
  logic        enc_a, enc_b, enc_z, res_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  enc_emulator #(.OUT_RES(14)) i_enc_emulator (
    .clk(clk), .rst(rst), .mode_n(mode_n), .res_sel(res_sel),
    .idx_en_n(idx_en_n), .angle(angle),
    .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z), .res_err(res_err)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] model(input logic [15:0] ang, input int code,
                                       input logic en_idx_n);
    int lsb;
    logic a, b, z;
    lsb = 6 - 2 * code;
    a = ang[lsb+1];
    b = ang[lsb] ^ ang[lsb+1];
    z = ((ang >> lsb) == 16'd0) && !en_idx_n;
    return {a, b, z};
  endfunction

  task automatic enter(input logic [1:0] code);
    mode_n  = 1'b1;
    res_sel = code;
    step(2);
    mode_n  = 1'b0;
    step(2);
  endtask

  task automatic t_reset;
    chk("R6 reset outputs", {enc_a, enc_b, enc_z, res_err}, 4'b0000);
  endtask

  task automatic t_idle;
    mode_n = 1'b1; idx_en_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      angle = 16'h00F0 << i;
      step(1);
      chk("R1 idle outputs low", {enc_a, enc_b, enc_z, 1'b0}, 4'b0000);
    end
    angle = 16'h0000; step(1);
    chk("R1 idle index low", {enc_a, enc_b, enc_z, 1'b0}, 4'b0000);
  endtask

  task automatic t_quad;
    logic [15:0] pats [4] = '{16'h0040, 16'h00BF, 16'h1234, 16'hFFFF};
    idx_en_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      enter(2'(c));
      foreach (pats[p]) begin
        angle = pats[p];
        step(1);
        chk("R2 R3 R4 quadrature", {enc_a, enc_b, enc_z, 1'b0},
            {model(pats[p], c, 1'b1), 1'b0});
      end
    end
    enter(2'd0);
    angle = 16'h003F; step(1);
    chk("R4 sub-LSB bits ignored", {enc_a, enc_b, enc_z, 1'b0}, 4'b0000);
  endtask

  task automatic t_hold;
    enter(2'd1);
    res_sel = 2'd3;
    angle = 16'h0010; step(2);
    chk("R5 res_sel ignored while low", {enc_a, enc_b, 2'b00},
        {model(16'h0010, 1, 1'b1), 1'b0} & 4'b1100);
    mode_n = 1'b1; res_sel = 2'd0; step(2);
    res_sel = 2'd2; step(1);
    mode_n = 1'b0; step(2);
    angle = 16'h0004; step(1);
    chk("R5 capture on fall only", {enc_a, enc_b, 2'b00}, 4'b0100);
  endtask

  task automatic t_index;
    enter(2'd0);
    idx_en_n = 1'b0;
    angle = 16'h003F; step(1);
    chk("R7 index in north window", {1'b0, 1'b0, enc_z, 1'b0}, 4'b0010);
    angle = 16'h0040; step(1);
    chk("R7 index off past window", {1'b0, 1'b0, enc_z, 1'b0}, 4'b0000);
    enter(2'd3);
    angle = 16'h0001; step(1);
    chk("R7 index narrow at 16 bits", {1'b0, 1'b0, enc_z, 1'b0}, 4'b0000);
    angle = 16'h0000; step(1);
    chk("R7 index at zero", {1'b0, 1'b0, enc_z, 1'b0}, 4'b0010);
    idx_en_n = 1'b1; step(1);
    chk("R8 index gated off", {1'b0, 1'b0, enc_z, 1'b0}, 4'b0000);
  endtask

  task automatic t_err;
    enter(2'd2);
    chk("R9 14 bits accepted", {3'b000, res_err}, 4'b0000);
    enter(2'd3);
    chk("R9 16 bits flagged", {3'b000, res_err}, 4'b0001);
    mode_n = 1'b1; res_sel = 2'd0; step(3);
    chk("R9 held without capture", {3'b000, res_err}, 4'b0001);
    mode_n = 1'b0; step(2);
    chk("R9 cleared on capture", {3'b000, res_err}, 4'b0000);
  endtask

  task automatic t_seq;
    logic [1:0] exp_ab [4] = '{2'b00, 2'b01, 2'b11, 2'b10};
    idx_en_n = 1'b1;
    enter(2'd1);
    for (int k = 0; k < 8; k++) begin
      angle = 16'(k << 4) | 16'h0003;
      step(1);
      chk("R10 B leads A", {enc_a, enc_b, 2'b00}, {exp_ab[k % 4], 2'b00});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; mode_n = 1'b1; res_sel = 2'd0; idx_en_n = 1'b1; angle = '0;
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_idle();
    t_quad();
    t_hold();
    t_index();
    t_err();
    t_seq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule